// File: doc/BRIEF.md
# Auto-Sleep Converter Sequencer

This block is the host-side controller for a 14-bit serial analog-to-digital converter that sleeps between samples. When a start request arrives, it drives a convert-start pulse of fixed width. The rising edge of that pulse wakes the converter, and the falling edge sets the sampling instant. The line is then left low, so the converter falls back asleep as soon as it reports the end of conversion. The controller synchronises the converter's busy line. After busy has been seen high and then low, it clocks in one 16-bit serial frame and presents the 14 result bits with a one-cycle valid strobe.

Every duration is a count of system clock cycles set by a parameter: the pulse width, the serial clock half period, the quiet time between the end of a read and the next convert edge, and the limit on how long busy may stay unresolved. Only two pulse-width windows are legal. A short window suits conversion on demand, and a wide window gives control over the sampling instant. A width that falls between the two windows, or outside the window chosen by the mode parameter, stops elaboration. A request that arrives while a cycle is still in progress is remembered and launched once the quiet time has run out.

Top module: `adc_sleep_seq`

## Requirements
- R1: While reset is applied, and until the first request after it, convert-start, serial clock, valid, pending and timeout are all low.
- R2: A start request sampled while idle drives convert-start high from the next cycle, for exactly PULSE_CYC cycles.
- R3: Once the pulse ends, convert-start stays low through the conversion, the read and the quiet time. The serial clock is never high while convert-start is high.
- R4: A read starts only after the synchronised busy line has been seen high and then low. Each read gives exactly 16 serial clock pulses, and the serial clock idles low between reads.
- R5: Every high phase and every low phase of the serial clock lasts SCLK_HALF cycles.
- R6: Serial data is sampled on each falling edge of the serial clock, most significant bit first. The first two frame bits are discarded, and result holds the last 14 bits received, so bit 13 is the third bit of the frame. Valid is high for one cycle, exactly 31*SCLK_HALF cycles after the serial clock first goes high. Result does not change at any other time.
- R7: When a request is waiting, the next convert-start pulse begins exactly GUARD_CYC+2 cycles after the valid cycle. The serial clock stays low in between.
- R8: A start request that arrives while a cycle is in progress sets pending. Pending is low again in the first cycle of the pulse it launches.
- R9: If busy has not completed a high-then-low sequence within TIMEOUT_CYC cycles after convert-start falls, timeout rises exactly TIMEOUT_CYC cycles after that fall. No read takes place, and the flag clears when the next pulse begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, one cycle |
| busy_i | input | 1 | Converter busy line (asynchronous) |
| sdata_i | input | 1 | Serial data from the converter |
| cnvst_o | output | 1 | Convert-start pulse to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | 14 | Last conversion result |
| valid_o | output | 1 | One-cycle strobe, result updated |
| pending_o | output | 1 | A request is waiting for the current cycle to end |
| timeout_o | output | 1 | Busy did not resolve in time on the last attempt |

## Verification
The convert-start pulse is visible in the cycle after the request edge and is counted sample by sample. The result and valid are due 31*SCLK_HALF cycles after the first serial clock high. The next pulse after a waiting request is due GUARD_CYC+2 cycles after valid, and timeout is due TIMEOUT_CYC cycles after the pulse falls. The bench samples every output half a period after each clock edge and counts these intervals in samples. It compares each count with the exact figure, not with a range, so a register added or lost on any path shows up as a count that is off by one.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_CONV,
    ST_READ,
    ST_GUARD
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= {STAGES{RST_VAL}};
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int PULSE_CYC   = 25,
  parameter int GUARD_CYC   = 64,
  parameter int TIMEOUT_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_s,
  input  logic rd_done,
  output logic cnvst_o,
  output logic launch_o,
  output logic pending_o,
  output logic timeout_o
);
  localparam int MAXC = max3(PULSE_CYC, GUARD_CYC, TIMEOUT_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_t st, st_d;
  logic [CW-1:0] cnt, cnt_d;
  logic seen, seen_d, pend, pend_d, tmo, tmo_d;

  always_comb begin
    st_d     = st;
    cnt_d    = cnt + 1'b1;
    seen_d   = seen;
    pend_d   = pend;
    tmo_d    = tmo;
    launch_o = 1'b0;
    case (st)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_i || pend) begin
          st_d   = ST_PULSE;
          pend_d = 1'b0;
          tmo_d  = 1'b0;
        end
      end
      ST_PULSE: begin
        if (cnt == CW'(PULSE_CYC - 1)) begin
          st_d   = ST_CONV;
          cnt_d  = '0;
          seen_d = 1'b0;
        end
      end
      ST_CONV: begin
        if (busy_s) seen_d = 1'b1;
        if (seen && !busy_s) begin
          st_d     = ST_READ;
          launch_o = 1'b1;
        end else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
          st_d  = ST_IDLE;
          tmo_d = 1'b1;
        end
      end
      ST_READ: begin
        cnt_d = '0;
        if (rd_done) st_d = ST_GUARD;
      end
      ST_GUARD: begin
        if (cnt == CW'(GUARD_CYC - 1)) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (start_i && st != ST_IDLE) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      seen <= 1'b0;
      pend <= 1'b0;
      tmo  <= 1'b0;
    end else begin
      st   <= st_d;
      cnt  <= cnt_d;
      seen <= seen_d;
      pend <= pend_d;
      tmo  <= tmo_d;
    end
  end

  assign cnvst_o   = (st == ST_PULSE);
  assign pending_o = pend;
  assign timeout_o = tmo;
endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
  parameter int SCLK_HALF  = 8,
  parameter int FRAME_BITS = 16,
  parameter int RES_BITS   = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                sdata_i,
  output logic                sclk_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] result_o
);
  localparam int PW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BW = $clog2(FRAME_BITS);

  logic act, act_d, sclk_q, sclk_d, done_q, done_d, shift_en;
  logic [PW-1:0] ph, ph_d;
  logic [BW-1:0] bitn, bit_d;
  logic [RES_BITS-1:0] sh, sh_d, res;

  assign sh_d = {sh[RES_BITS-2:0], sdata_i};

  always_comb begin
    act_d    = act;
    sclk_d   = sclk_q;
    ph_d     = ph;
    bit_d    = bitn;
    done_d   = 1'b0;
    shift_en = 1'b0;
    if (launch && !act) begin
      act_d  = 1'b1;
      sclk_d = 1'b1;
      ph_d   = '0;
      bit_d  = '0;
    end else if (act) begin
      if (ph == PW'(SCLK_HALF - 1)) begin
        ph_d = '0;
        if (sclk_q) begin
          sclk_d   = 1'b0;
          shift_en = 1'b1;
          if (bitn == BW'(FRAME_BITS - 1)) begin
            act_d  = 1'b0;
            done_d = 1'b1;
          end
        end else begin
          sclk_d = 1'b1;
          bit_d  = bitn + 1'b1;
        end
      end else begin
        ph_d = ph + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      sclk_q <= 1'b0;
      ph     <= '0;
      bitn   <= '0;
      done_q <= 1'b0;
      sh     <= '0;
      res    <= '0;
    end else begin
      act    <= act_d;
      sclk_q <= sclk_d;
      ph     <= ph_d;
      bitn   <= bit_d;
      done_q <= done_d;
      if (shift_en) sh  <= sh_d;
      if (done_d)   res <= sh_d;
    end
  end

  assign sclk_o   = sclk_q;
  assign done_o   = done_q;
  assign result_o = res;
endmodule

// File: rtl/adc_sleep_seq.sv
module adc_sleep_seq #(
  parameter bit LONG_MODE     = 1'b0,
  parameter int PULSE_CYC     = 25,
  parameter int SHORT_MIN_CYC = 10,
  parameter int SHORT_MAX_CYC = 500,
  parameter int LONG_MIN_CYC  = 1500,
  parameter int SCLK_HALF     = 8,
  parameter int GUARD_CYC     = 64,
  parameter int TIMEOUT_CYC   = 4000,
  parameter int FRAME_BITS    = 16,
  parameter int RES_BITS      = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                busy_i,
  input  logic                sdata_i,
  output logic                cnvst_o,
  output logic                sclk_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                valid_o,
  output logic                pending_o,
  output logic                timeout_o
);
  localparam bit PULSE_OK = LONG_MODE ? (PULSE_CYC > LONG_MIN_CYC)
                                      : (PULSE_CYC >= SHORT_MIN_CYC && PULSE_CYC <= SHORT_MAX_CYC);

  generate
    if (!PULSE_OK) begin : g_bad_width
      $error("convert-start width lies outside the legal window for the selected mode");
    end
  endgenerate

  logic rst_sn, busy_s, launch, rd_done;

  adc_seq_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_sn)
  );

  adc_seq_sync #(.STAGES(2), .RST_VAL(1'b0)) u_busy_sync (
    .clk(clk), .rst_n(rst_sn), .din(busy_i), .dout(busy_s)
  );

  adc_seq_ctrl #(
    .PULSE_CYC(PULSE_CYC), .GUARD_CYC(GUARD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .start_i(start_i), .busy_s(busy_s),
    .rd_done(rd_done), .cnvst_o(cnvst_o), .launch_o(launch),
    .pending_o(pending_o), .timeout_o(timeout_o)
  );

  adc_seq_shifter #(
    .SCLK_HALF(SCLK_HALF), .FRAME_BITS(FRAME_BITS), .RES_BITS(RES_BITS)
  ) u_shift (
    .clk(clk), .rst_n(rst_sn), .launch(launch), .sdata_i(sdata_i),
    .sclk_o(sclk_o), .done_o(rd_done), .result_o(result_o)
  );

  assign valid_o = rd_done;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int PULSE_CYC  = 25,
  parameter int FRAME_BITS = 16,
  parameter int RES_BITS   = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cnvst_o,
  input logic                sclk_o,
  input logic                valid_o,
  input logic [RES_BITS-1:0] result_o,
  input logic                pending_o,
  input logic                timeout_o
);
  logic [31:0] hi_cnt;
  logic [7:0]  rise_cnt;
  logic        sclk_prev, cnv_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      rise_cnt  <= '0;
      sclk_prev <= 1'b0;
      cnv_prev  <= 1'b0;
    end else begin
      sclk_prev <= sclk_o;
      cnv_prev  <= cnvst_o;
      hi_cnt    <= cnvst_o ? hi_cnt + 1 : '0;
      if (cnvst_o && !cnv_prev)      rise_cnt <= '0;
      else if (sclk_o && !sclk_prev) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnvst_o) |-> hi_cnt == PULSE_CYC);

  p_no_sclk_in_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnvst_o |-> !sclk_o);

  p_sixteen_clocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnvst_o) |-> (rise_cnt == 0 || rise_cnt == FRAME_BITS));

  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_result_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o));

  p_pending_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnvst_o) |-> !pending_o);

  p_timeout_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !sclk_o);
endmodule

bind adc_sleep_seq adc_seq_chk #(
  .PULSE_CYC(PULSE_CYC), .FRAME_BITS(FRAME_BITS), .RES_BITS(RES_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnvst_o(cnvst_o), .sclk_o(sclk_o),
  .valid_o(valid_o), .result_o(result_o), .pending_o(pending_o),
  .timeout_o(timeout_o)
);

// File: tb/sim_adc_sleep_seq.sv
`timescale 1ns/1ps
module sim_adc_sleep_seq;
  localparam int PULSE = 25;
  localparam int HALF  = 8;
  localparam int GUARD = 64;
  localparam int TMO   = 4000;
  localparam int NV    = 6;
  // {16-bit frame driven by the converter model, expected 14-bit result}
  localparam logic [29:0] VEC [NV] = '{
    {16'h0000, 14'h0000}, {16'h3FFF, 14'h3FFF}, {16'hEAAA, 14'h2AAA},
    {16'h9555, 14'h1555}, {16'h6001, 14'h2001}, {16'h0F0F, 14'h0F0F}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, busy = 1'b0, sdata = 1'b0;
  logic cnvst, sclk, valid, pending, timeout;
  logic [13:0] result;
  logic [15:0] frame = 16'h0;
  logic busy_en = 1'b1, req_mid = 1'b0, pend_seen = 1'b0;
  int idx = 0, n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  adc_sleep_seq #(.PULSE_CYC(PULSE), .SCLK_HALF(HALF), .GUARD_CYC(GUARD),
                  .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy), .sdata_i(sdata),
    .cnvst_o(cnvst), .sclk_o(sclk), .result_o(result), .valid_o(valid),
    .pending_o(pending), .timeout_o(timeout)
  );

  // converter model: busy after the sampling edge, data shifted on falling sclk
  always begin
    @(negedge cnvst);
    if (busy_en) begin
      repeat (3) @(posedge clk);
      #1 busy = 1'b1;
      repeat (50) @(posedge clk);
      #1 busy = 1'b0;
    end
  end
  always @(posedge cnvst) begin idx = 0; sdata = frame[15]; end
  always @(negedge sclk) begin
    #1 idx = idx + 1;
    sdata = (idx < 16) ? frame[15 - idx] : 1'b0;
  end
  always @(posedge sclk) begin
    if (req_mid) begin
      req_mid = 1'b0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      pend_seen = pending;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fire();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // called on the first sample with cnvst high
  task automatic watch_conv(input logic [13:0] exp);
    int n, m, hi, rises;
    bit prev, bad3, early;
    n = 1; bad3 = 0; early = 0;
    forever begin
      @(negedge clk);
      if (cnvst) n++; else break;
    end
    chk(n == PULSE, "R2 pulse width", n, PULSE);
    while (!sclk) begin
      if (cnvst) bad3 = 1;
      @(negedge clk);
    end
    if (busy) early = 1;
    chk(!early, "R4 read before busy fell", early, 0);
    m = 0; hi = 1; rises = 1; prev = 1'b1;
    while (!valid) begin
      @(negedge clk);
      m++;
      if (sclk) hi++;
      if (sclk && !prev) rises++;
      prev = sclk;
      if (cnvst) bad3 = 1;
    end
    chk(!bad3, "R3 cnvst low during conversion", bad3, 0);
    chk(rises == 16, "R4 sclk pulses", rises, 16);
    chk(hi == 16 * HALF, "R5 sclk high cycles", hi, 16 * HALF);
    chk(m == 31 * HALF, "R6 valid latency", m, 31 * HALF);
    chk(result == exp, "R6 result", result, exp);
    @(negedge clk);
    chk(!valid && result == exp, "R6 single valid, held result", valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    bit bad;
    repeat (3) @(negedge clk);
    chk(!cnvst && !sclk && !valid && !pending && !timeout, "R1 in reset",
        {cnvst, sclk, valid, pending, timeout}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cnvst && !sclk && !valid && !pending && !timeout, "R1 after reset",
        {cnvst, sclk, valid, pending, timeout}, 0);

    for (int i = 0; i < NV; i++) begin
      frame = VEC[i][29:14];
      fire();
      chk(cnvst, "R2 pulse starts", cnvst, 1);
      watch_conv(VEC[i][13:0]);
      repeat (GUARD + 4) @(negedge clk);
    end

    // request during a read, then quiet time to the next pulse
    frame = 16'h1234;
    req_mid = 1'b1;
    fire();
    watch_conv(14'h1234);
    chk(pend_seen, "R8 pending set", pend_seen, 1);
    frame = 16'h2ABC;
    k = 1; bad = 0;
    while (!cnvst) begin
      @(negedge clk);
      k++;
      if (sclk) bad = 1;
    end
    chk(k == GUARD + 2, "R7 quiet time", k, GUARD + 2);
    chk(!bad, "R7 sclk idle", bad, 0);
    chk(!pending, "R8 pending cleared", pending, 0);
    watch_conv(14'h2ABC);
    repeat (GUARD + 4) @(negedge clk);

    // busy never answers
    busy_en = 1'b0;
    fire();
    while (cnvst) @(negedge clk);
    k = 0; bad = 0;
    while (!timeout && k < TMO + 10) begin
      @(negedge clk);
      k++;
      if (sclk) bad = 1;
    end
    chk(k == TMO, "R9 timeout latency", k, TMO);
    chk(!bad && !valid, "R9 no read", bad, 0);
    busy_en = 1'b1;
    frame = 16'h0555;
    fire();
    chk(!timeout && cnvst, "R9 timeout cleared", timeout, 0);
    watch_conv(14'h0555);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule